// File: doc/BRIEF.md
# Delay Slot Fetch and Annul Controller

This block steers instruction fetch for a five-stage in-order pipeline. Branches resolve in decode and have one architectural delay slot. In the cycle a branch is decoded, fetch is already reading the instruction after it, which is the delay slot. The block chooses the following fetch address: the branch target if the branch is taken, or the next sequential word if it is not. The delay slot therefore always gets fetched.

Each branch carries an annul flag. With the flag clear, the slot instruction commits whatever the branch does. With the flag set, the slot instruction commits only when the branch is taken. When it does not commit, the block raises a kill strobe while the slot instruction sits in decode. It also drops that instruction's valid bit as it enters the decode-to-execute register, so the instruction moves on as a bubble.

A branch found in a delay slot is illegal. It raises an error pulse and is otherwise ignored. A stall freezes every register, so an annul decision is applied exactly once.

Top module: `dslot_fetch_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `fetch_pc_o` is RESET_PC (0 by default), and `slot_kill_o`, `ex_valid_o` and `slot_err_o` are all 0.
- R2: In a clock without stall and without an accepted taken branch, `fetch_pc_o` advances by INST_BYTES (4) at the next clock.
- R3: An accepted branch is one with `dec_valid_i` and `dec_is_branch_i` high that is not in a delay slot. If it is taken, `fetch_pc_o` becomes `dec_target_i` at the next clock. The delay slot is the address that `fetch_pc_o` showed in the cycle the branch was decoded.
- R4: An accepted branch with `dec_annul_i` low never kills its slot: `slot_kill_o` stays 0 in the next cycle, whether the branch is taken or not.
- R5: An accepted branch with `dec_annul_i` high that is taken does not kill its slot: `slot_kill_o` stays 0 in the next cycle.
- R6: An accepted branch with `dec_annul_i` high that is not taken raises `slot_kill_o` for the cycle its slot is in decode. After that cycle, `ex_valid_o` is 0.
- R7: In a clock without stall, `ex_valid_o` takes the value of `dec_valid_i` at the next clock, unless `slot_kill_o` was high in that clock, in which case it takes 0.
- R8: A valid branch decoded while the decode instruction is a delay slot raises `slot_err_o` for one cycle. It causes no redirect, no kill and no new delay slot.
- R9: While `stall_i` is high, `fetch_pc_o`, `slot_kill_o`, `ex_valid_o`, `slot_err_o` and the delay-slot state all hold their values. A pending kill is applied once, after the stall ends.
- R10: A branch with `dec_valid_i` low is ignored: no redirect, no kill and no delay slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze all state for this clock |
| dec_valid_i | input | 1 | Decode stage holds a valid instruction |
| dec_is_branch_i | input | 1 | Decode instruction is a conditional branch |
| dec_annul_i | input | 1 | Branch annul flag: kill slot when not taken |
| dec_taken_i | input | 1 | Branch outcome from the decode zero test |
| dec_target_i | input | PC_W | Branch target from the decode adder |
| fetch_pc_o | output | PC_W | Address fetched this cycle |
| slot_kill_o | output | 1 | Instruction now in decode is a nullified delay slot |
| ex_valid_o | output | 1 | Valid bit of the decode-to-execute register |
| slot_err_o | output | 1 | A branch was found in a delay slot |

## Verification
The bench builds the block with its default parameters: a 32-bit PC, a 4-byte step and a reset PC of 0. With these values, sequential fetch addresses and word-aligned targets follow from plain arithmetic. The control state is only three bits, so a directed sweep covers every combination of annul flag, outcome and stall placement around a branch, plus a branch inside a slot and an invalid branch. A long pseudo-random stream of branches, stalls and bubbles then exercises back-to-back branches and stalls that straddle a kill. Every cycle is compared against an arithmetic model.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  // Decode-stage control bits seen by the fetch controller
  typedef struct packed {
    logic valid;
    logic is_br;
    logic annul;
    logic taken;
  } dec_ctl_t;

  // Delay-slot tracking state carried between cycles
  typedef struct packed {
    logic in_slot;  // instruction now in decode is a delay slot
    logic kill;     // that slot instruction is nullified
    logic err;      // a branch was seen inside a slot last cycle
  } slot_st_t;

  // Next slot state for one decoded instruction
  function automatic slot_st_t slot_next(input dec_ctl_t c, input slot_st_t cur);
    slot_st_t n;
    logic     accept;
    accept    = c.valid & c.is_br & ~cur.in_slot;
    n.in_slot = accept;
    n.kill    = accept & c.annul & ~c.taken;
    n.err     = c.valid & c.is_br & cur.in_slot;
    return n;
  endfunction

endpackage

// File: rtl/dslot_pc_gen.sv
module dslot_pc_gen #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter logic [63:0] RESET_PC   = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            redirect,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] STEP   = PC_W'(INST_BYTES);
  localparam logic [PC_W-1:0] PC_RST = PC_W'(RESET_PC);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_seq;
  logic [PC_W-1:0] pc_nxt;

  assign pc_seq = pc_q + STEP;

  always_comb begin
    if (hold)          pc_nxt = pc_q;
    else if (redirect) pc_nxt = target;
    else               pc_nxt = pc_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= PC_RST;
    else     pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/dslot_slot_track.sv
module dslot_slot_track
  import dslot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  dec_ctl_t ctl,
  output slot_st_t st_o,
  output logic     redirect_o
);
  slot_st_t st_q;
  slot_st_t st_nxt;

  always_comb begin
    st_nxt = slot_next(ctl, st_q);
  end

  // Redirect only for an accepted (not-in-slot) taken branch
  assign redirect_o = ~hold & ctl.valid & ctl.is_br & ctl.taken & ~st_q.in_slot;

  always_ff @(posedge clk) begin
    if (rst)        st_q <= '0;
    else if (!hold) st_q <= st_nxt;
  end

  assign st_o = st_q;
endmodule

// File: rtl/dslot_idex_valid.sv
module dslot_idex_valid (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic dec_valid,
  input  logic kill,
  output logic ex_valid_o
);
  logic v_q;

  always_ff @(posedge clk) begin
    if (rst)        v_q <= 1'b0;
    else if (!hold) v_q <= dec_valid & ~kill;
  end

  assign ex_valid_o = v_q;
endmodule

// File: rtl/dslot_fetch_ctrl.sv
module dslot_fetch_ctrl
  import dslot_pkg::*;
#(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INST_BYTES = 4,
  parameter logic [63:0] RESET_PC   = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall_i,
  input  logic            dec_valid_i,
  input  logic            dec_is_branch_i,
  input  logic            dec_annul_i,
  input  logic            dec_taken_i,
  input  logic [PC_W-1:0] dec_target_i,
  output logic [PC_W-1:0] fetch_pc_o,
  output logic            slot_kill_o,
  output logic            ex_valid_o,
  output logic            slot_err_o
);
  dec_ctl_t ctl;
  slot_st_t st;
  logic     redirect;

  assign ctl.valid = dec_valid_i;
  assign ctl.is_br = dec_is_branch_i;
  assign ctl.annul = dec_annul_i;
  assign ctl.taken = dec_taken_i;

  dslot_slot_track u_track (
    .clk        (clk),
    .rst        (rst),
    .hold       (stall_i),
    .ctl        (ctl),
    .st_o       (st),
    .redirect_o (redirect)
  );

  dslot_pc_gen #(
    .PC_W       (PC_W),
    .INST_BYTES (INST_BYTES),
    .RESET_PC   (RESET_PC)
  ) u_pc (
    .clk      (clk),
    .rst      (rst),
    .hold     (stall_i),
    .redirect (redirect),
    .target   (dec_target_i),
    .pc_o     (fetch_pc_o)
  );

  dslot_idex_valid u_idex (
    .clk        (clk),
    .rst        (rst),
    .hold       (stall_i),
    .dec_valid  (dec_valid_i),
    .kill       (st.kill),
    .ex_valid_o (ex_valid_o)
  );

  assign slot_kill_o = st.kill;
  assign slot_err_o  = st.err;
endmodule

// File: rtl/dslot_fetch_ctrl_chk.sv
module dslot_fetch_ctrl_chk #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INST_BYTES = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            stall_i,
  input logic            dec_valid_i,
  input logic            dec_is_branch_i,
  input logic            dec_annul_i,
  input logic            dec_taken_i,
  input logic [PC_W-1:0] fetch_pc_o,
  input logic            slot_kill_o,
  input logic            ex_valid_o,
  input logic            slot_err_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !(dec_valid_i && dec_is_branch_i && dec_taken_i))
      |=> fetch_pc_o == $past(fetch_pc_o) + STEP);

  a_r4_plain_slot_kept: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && dec_valid_i && dec_is_branch_i && !dec_annul_i) |=> !slot_kill_o);

  a_r5_taken_slot_kept: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && dec_valid_i && dec_is_branch_i && dec_taken_i) |=> !slot_kill_o);

  a_r6_kill_bubble: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && slot_kill_o) |=> !ex_valid_o);

  a_r7_invalid_bubble: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !dec_valid_i) |=> !ex_valid_o);

  a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && slot_err_o) |=> !slot_err_o);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> ($stable(fetch_pc_o) && $stable(slot_kill_o) &&
                 $stable(ex_valid_o) && $stable(slot_err_o)));

  a_r10_invalid_no_kill: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !dec_valid_i) |=> (!slot_kill_o && !slot_err_o));
endmodule

bind dslot_fetch_ctrl dslot_fetch_ctrl_chk #(
  .PC_W       (PC_W),
  .INST_BYTES (INST_BYTES)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .stall_i         (stall_i),
  .dec_valid_i     (dec_valid_i),
  .dec_is_branch_i (dec_is_branch_i),
  .dec_annul_i     (dec_annul_i),
  .dec_taken_i     (dec_taken_i),
  .fetch_pc_o      (fetch_pc_o),
  .slot_kill_o     (slot_kill_o),
  .ex_valid_o      (ex_valid_o),
  .slot_err_o      (slot_err_o)
);

// File: tb/dslot_fetch_ctrl_bench.sv
module dslot_fetch_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall_i = 1'b0;
  logic        dec_valid_i = 1'b0;
  logic        dec_is_branch_i = 1'b0;
  logic        dec_annul_i = 1'b0;
  logic        dec_taken_i = 1'b0;
  logic [31:0] dec_target_i = '0;
  logic [31:0] fetch_pc_o;
  logic        slot_kill_o;
  logic        ex_valid_o;
  logic        slot_err_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected state
  logic [31:0] m_pc;
  logic        m_slot, m_kill, m_err, m_exv;
  logic [31:0] rnd = 32'h1234_5677;

  always #2.5 clk = ~clk;

  dslot_fetch_ctrl u_dslot_fetch_ctrl (
    .clk             (clk),
    .rst             (rst),
    .stall_i         (stall_i),
    .dec_valid_i     (dec_valid_i),
    .dec_is_branch_i (dec_is_branch_i),
    .dec_annul_i     (dec_annul_i),
    .dec_taken_i     (dec_taken_i),
    .dec_target_i    (dec_target_i),
    .fetch_pc_o      (fetch_pc_o),
    .slot_kill_o     (slot_kill_o),
    .ex_valid_o      (ex_valid_o),
    .slot_err_o      (slot_err_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rnd(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Drive one cycle at the falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic step(input logic v, input logic b, input logic a, input logic t,
                      input logic [31:0] tg, input logic s);
    logic  acc;
    string tp, tk, tv;
    stall_i = s; dec_valid_i = v; dec_is_branch_i = b;
    dec_annul_i = a; dec_taken_i = t; dec_target_i = tg;
    acc = v & b & ~m_slot;
    tp = s ? "R9" : (!v && b) ? "R10" : (acc && t) ? "R3" : "R2";
    tk = s ? "R9" : (!v && b) ? "R10" : (acc && !a) ? "R4" : (acc && t) ? "R5" : "R6";
    tv = s ? "R9" : m_kill ? "R6" : "R7";
    @(posedge clk);
    if (!s) begin
      m_err  = v & b & m_slot;
      m_exv  = v & ~m_kill;
      m_kill = acc & a & ~t;
      m_slot = acc;
      m_pc   = (acc && t) ? tg : m_pc + 32'd4;
    end
    @(negedge clk);
    chk(tp,   "fetch_pc",  fetch_pc_o,        m_pc);
    chk(tk,   "slot_kill", {31'd0, slot_kill_o}, {31'd0, m_kill});
    chk(tv,   "ex_valid",  {31'd0, ex_valid_o},  {31'd0, m_exv});
    chk(s ? "R9" : "R8", "slot_err", {31'd0, slot_err_o}, {31'd0, m_err});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pc = 32'd0; m_slot = 0; m_kill = 0; m_err = 0; m_exv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "fetch_pc",  fetch_pc_o, 32'd0);
    chk("R1", "slot_kill", {31'd0, slot_kill_o}, 32'd0);
    chk("R1", "ex_valid",  {31'd0, ex_valid_o}, 32'd0);
    chk("R1", "slot_err",  {31'd0, slot_err_o}, 32'd0);

    // sequential fetch
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, '0, 0);

    // sweep annul x outcome x stall placement around a branch
    for (int a = 0; a < 2; a++)
      for (int t = 0; t < 2; t++)
        for (int sp = 0; sp < 3; sp++) begin
          logic [31:0] tg;
          tg = 32'h0000_1000 + 32'(a * 256 + t * 64 + sp * 16);
          if (sp == 1) step(1, 1, 1'(a), 1'(t), tg, 1);   // stalled branch
          step(1, 1, 1'(a), 1'(t), tg, 0);                 // branch accepted
          if (sp == 2) begin                               // stall over the slot
            step(1, 0, 0, 0, '0, 1);
            step(1, 0, 0, 0, '0, 1);
          end
          step(1, 0, 0, 0, '0, 0);                         // slot in decode
          step(1, 0, 0, 0, '0, 0);
          step(0, 0, 0, 0, '0, 0);
        end

    // branch inside a delay slot
    step(1, 1, 1, 0, 32'h0000_2000, 0);
    step(1, 1, 1, 1, 32'h0000_3000, 0);
    step(1, 1, 0, 1, 32'h0000_4000, 0);
    step(1, 0, 0, 0, '0, 0);
    step(1, 0, 0, 0, '0, 0);

    // invalid branch ignored
    step(0, 1, 1, 1, 32'h0000_5000, 0);
    step(0, 1, 1, 0, 32'h0000_6000, 0);
    step(1, 0, 0, 0, '0, 0);

    // pseudo-random stream
    for (int i = 0; i < 3000; i++) begin
      rnd = next_rnd(rnd);
      step(rnd[2:0] != 3'd0, rnd[4:3] == 2'd0, rnd[5], rnd[6],
           {rnd[31:10], 10'd0} | {22'd0, rnd[9:8], 8'd0}, rnd[8:7] == 2'd3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule